// File: doc/BRIEF.md
# Nonvolatile Memory Busy and Power Gate

This block sits between the CPU bus and an on-chip nonvolatile memory array. It keeps an operation-active flag that a program/erase engine sets and clears. While the flag is set, the block shields the array from the bus. Reads of the array return an all-ones byte, which the CPU decodes as a harmless no-op opcode, and writes to the array are dropped. The block also holds a small control register and a status register. The status register carries a sticky failure flag and a per-sector activity vector, where one bit merges the upper main sectors when the array has more than four of them.

The block also gates the array's power states. A wait-for-interrupt request puts the array into standby or power-down, chosen by a control bit. A halt or stop request always chooses power-down. Either kind of request waits until any running operation has finished. Leaving power-down, and leaving reset, opens a recovery window of a fixed number of cycles. During that window the array counts as busy, and array accesses are held off with a wait signal. At the end of each completed operation a one-cycle end-of-write pulse is produced, and a control bit selects whether that event or an external pin feeds the shared interrupt line.

Top module: `nvm_pwr_gate`

## Requirements
- R1: A pulse on `op_start` sets the operation-active flag, seen on `busy` in the next cycle. A pulse on `op_done` or `op_suspend` clears the flag at the next clock edge, unless `op_start` comes in the same cycle, in which case `op_start` wins.
- R2: While the operation-active flag is set and the gate is not stalling, an array read (`bus_sel_mem`=1, `bus_we`=0) returns 8'hFF with `mem_re` low. An array write leaves `mem_we` low.
- R3: When the gate is idle and no operation is active, an array read passes `mem_rdata` to `bus_rdata` in the same cycle with `mem_re` high and `bus_wait` low. An array write raises `mem_we`.
- R4: A wait-for-interrupt request (`lp_req`=1, `lp_halt`=0) enters standby (`arr_stby`=1) when control bit 0 is 0, and power-down (`arr_pd`=1) when control bit 0 is 1. `lp_wake` in standby returns to full access at the next edge with no recovery.
- R5: A halt/stop request (`lp_req`=1, `lp_halt`=1) enters power-down whatever the value of control bit 0.
- R6: A low-power request made while an operation is active is deferred. The target state is entered at the clock edge that follows the edge at which the flag clears.
- R7: After reset release, `busy` stays high for PWRUP_CYC cycles. After `lp_wake` in power-down, `busy` stays high for RECOV_CYC cycles. Array accesses during either window, and during standby or power-down, raise `bus_wait`.
- R8: Status bit 7 (register address 1) resets to 0 and is set by an `op_err` pulse. It is cleared only by a register write to address 1 with data bit 7 equal to 0. A set that arrives in the same cycle as a clear wins over the clear.
- R9: Status bits 6:0 are read-only. Bit 6 is `test_busy`, bits 5:4 are `eep_busy[1:0]`, bits 2:0 are `main_busy[2:0]`, and bit 3 is the OR of `main_busy[MAIN_SECT-1:3]`. Writes do not change these bits.
- R10: `eow_irq` pulses for one cycle, in the cycle after an `op_done` ends an active operation. A suspend produces no pulse.
- R11: The control register at address 0 resets to 0 and reads back its written bits 1:0, with bits 7:2 reading as 0. Bit 1 drives `irq_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_sel_mem | input | 1 | 1 = array access, 0 = register access |
| bus_addr | input | ADDR_W | Array address, or register index (0 control, 1 status) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the request cycle |
| bus_wait | output | 1 | Array access must be retried |
| mem_rdata | input | 8 | Data from the array |
| mem_addr | output | ADDR_W | Address to the array |
| mem_wdata | output | 8 | Write data to the array |
| mem_re | output | 1 | Array read enable |
| mem_we | output | 1 | Array write enable |
| op_start | input | 1 | Operation begins (first address latched or chip erase) |
| op_done | input | 1 | Operation completed |
| op_suspend | input | 1 | Sector erase suspended |
| op_err | input | 1 | Operation failed |
| test_busy | input | 1 | Test/OTP area under modification |
| eep_busy | input | 2 | Emulated-EEPROM sectors under modification |
| main_busy | input | MAIN_SECT | Main sectors under modification |
| lp_req | input | 1 | CPU low-power request |
| lp_halt | input | 1 | 1 = halt/stop, 0 = wait-for-interrupt |
| lp_wake | input | 1 | CPU leaves low power |
| busy | output | 1 | Operation active or recovery window open |
| arr_stby | output | 1 | Array in standby |
| arr_pd | output | 1 | Array in power-down |
| eow_irq | output | 1 | End-of-write pulse |
| irq_sel | output | 1 | Shared interrupt source: 1 end-of-write, 0 pin |

## Verification
The hardest situation to reach is a low-power request that arrives while an operation is still running. It has to be deferred, and the target state must not appear until one edge after the flag drops. The bench starts an operation, issues a halt request, holds for several cycles, then completes the operation and samples `arr_pd` at each of the two following edges. The merged main-sector bit is covered by a sweep over all 512 combinations of the sector inputs in a six-sector configuration.

// File: rtl/nvm_gate_pkg.sv
// Shared types and constants for the nonvolatile memory power gate.
// Assumes an 8-bit data bus and two register slots at indices 0 and 1.
package nvm_gate_pkg;
    typedef enum logic [2:0] {
        PS_ACTIVE = 3'd0,
        PS_PEND   = 3'd1,
        PS_STBY   = 3'd2,
        PS_PDN    = 3'd3,
        PS_RECOV  = 3'd4
    } pwr_state_t;

    localparam int          REG_CTRL  = 0;
    localparam int          REG_STAT  = 1;
    localparam logic [7:0]  NOP_BYTE  = 8'hFF;
endpackage

// File: rtl/nvm_busy_track.sv
// Operation-active flag, end-of-write pulse and sticky failure flag.
// Assumes start/done/suspend/err are single-cycle strobes from the engine.
module nvm_busy_track (
    input  logic clk,
    input  logic rst_n,
    input  logic op_start,
    input  logic op_done,
    input  logic op_suspend,
    input  logic op_err,
    input  logic err_clr,
    output logic op_busy,
    output logic eow_irq,
    output logic err_flag
);
    // Operation flag: start has priority over end.
    always_ff @(posedge clk) begin
        if (!rst_n)                      op_busy <= 1'b0;
        else if (op_start)               op_busy <= 1'b1;
        else if (op_done || op_suspend)  op_busy <= 1'b0;
    end

    // End-of-write pulse on completion only.
    always_ff @(posedge clk) begin
        if (!rst_n) eow_irq <= 1'b0;
        else        eow_irq <= op_busy && op_done && !op_start;
    end

    // Sticky failure flag: hardware set beats software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        err_flag <= 1'b0;
        else if (op_err)   err_flag <= 1'b1;
        else if (err_clr)  err_flag <= 1'b0;
    end

    a_r1_start_sets: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> op_busy);
    a_r10_eow_needs_op: assert property (@(posedge clk) disable iff (!rst_n)
        eow_irq |-> $past(op_busy));
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag);
endmodule

// File: rtl/nvm_pwr_seq.sv
// Power-state sequencer: active, deferred entry, standby, power-down, recovery.
// Assumes lp_req and lp_wake are strobes; recovery windows are cycle counts.
module nvm_pwr_seq
    import nvm_gate_pkg::*;
#(
    parameter int PWRUP_CYC = 16,
    parameter int RECOV_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lp_req,
    input  logic lp_halt,
    input  logic lp_wake,
    input  logic pd_on_wfi,
    input  logic op_busy,
    output logic arr_stby,
    output logic arr_pd,
    output logic in_recov,
    output logic mem_stall
);
    localparam int MAX_CYC = (PWRUP_CYC > RECOV_CYC) ? PWRUP_CYC : RECOV_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    pwr_state_t       state;
    logic             tgt_pd;
    logic [CNT_W-1:0] cnt;
    logic             want_pd;

    // Target of a new request: halt/stop always powers down.
    always_comb want_pd = lp_halt || pd_on_wfi;

    // State, pending target and recovery counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= PS_RECOV;
            tgt_pd <= 1'b0;
            cnt    <= CNT_W'(PWRUP_CYC - 1);
        end else begin
            case (state)
                PS_ACTIVE: if (lp_req) begin
                    tgt_pd <= want_pd;
                    if (op_busy)      state <= PS_PEND;
                    else if (want_pd) state <= PS_PDN;
                    else              state <= PS_STBY;
                end
                PS_PEND: begin
                    if (lp_wake)       state <= PS_ACTIVE;
                    else if (!op_busy) state <= tgt_pd ? PS_PDN : PS_STBY;
                end
                PS_STBY: if (lp_wake) state <= PS_ACTIVE;
                PS_PDN: if (lp_wake) begin
                    state <= PS_RECOV;
                    cnt   <= CNT_W'(RECOV_CYC - 1);
                end
                PS_RECOV: begin
                    if (cnt == '0) state <= PS_ACTIVE;
                    else           cnt   <= cnt - 1'b1;
                end
                default: state <= PS_ACTIVE;
            endcase
        end
    end

    // Decoded state outputs.
    always_comb begin
        arr_stby  = (state == PS_STBY);
        arr_pd    = (state == PS_PDN);
        in_recov  = (state == PS_RECOV);
        mem_stall = (state == PS_STBY) || (state == PS_PDN) || (state == PS_RECOV);
    end

    a_r7_recov_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_RECOV && cnt == '0) |=> state == PS_ACTIVE);
    a_r6_defer_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_PEND && op_busy) |=> (state == PS_PEND || state == PS_ACTIVE));
    a_r4_stby_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_STBY && !lp_wake) |=> state == PS_STBY);
endmodule

// File: rtl/nvm_sect_map.sv
// Folds per-sector activity into the 7-bit status field.
// Assumes MAIN_SECT >= 4; sectors 3 and up share status bit 3.
module nvm_sect_map #(
    parameter int MAIN_SECT = 4
) (
    input  logic                 test_busy,
    input  logic [1:0]           eep_busy,
    input  logic [MAIN_SECT-1:0] main_busy,
    output logic [6:0]           sect_stat
);
    logic upper_any;

    generate
        if (MAIN_SECT > 4) begin : g_merge
            // Several upper sectors share one bit.
            always_comb upper_any = |main_busy[MAIN_SECT-1:3];
        end else begin : g_single
            // One sector per bit.
            always_comb upper_any = main_busy[3];
        end
    endgenerate

    // Field layout: test area, emulated sectors, main sectors.
    always_comb sect_stat = {test_busy, eep_busy, upper_any, main_busy[2:0]};
endmodule

// File: rtl/nvm_pwr_gate.sv
// Top: bus gating for the array, control/status registers, power sequencing.
// Assumes a single-cycle bus; read data is combinational in the request cycle.
module nvm_pwr_gate
    import nvm_gate_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int MAIN_SECT = 4,
    parameter int PWRUP_CYC = 16,
    parameter int RECOV_CYC = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic                 bus_sel_mem,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [7:0]           bus_wdata,
    output logic [7:0]           bus_rdata,
    output logic                 bus_wait,
    input  logic [7:0]           mem_rdata,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [7:0]           mem_wdata,
    output logic                 mem_re,
    output logic                 mem_we,
    input  logic                 op_start,
    input  logic                 op_done,
    input  logic                 op_suspend,
    input  logic                 op_err,
    input  logic                 test_busy,
    input  logic [1:0]           eep_busy,
    input  logic [MAIN_SECT-1:0] main_busy,
    input  logic                 lp_req,
    input  logic                 lp_halt,
    input  logic                 lp_wake,
    output logic                 busy,
    output logic                 arr_stby,
    output logic                 arr_pd,
    output logic                 eow_irq,
    output logic                 irq_sel
);
    logic [1:0] ctrl_q;
    logic       op_busy, err_flag, in_recov, mem_stall;
    logic       reg_wr, ctrl_hit, stat_hit, err_clr;
    logic       mem_rd_ok, mem_wr_ok;
    logic [6:0] sect_stat;

    // Register decode for the two control slots.
    always_comb begin
        ctrl_hit = (bus_addr == ADDR_W'(REG_CTRL));
        stat_hit = (bus_addr == ADDR_W'(REG_STAT));
        reg_wr   = bus_req && bus_we && !bus_sel_mem;
        err_clr  = reg_wr && stat_hit && !bus_wdata[7];
    end

    // Control register: bit 0 power-down on wait, bit 1 interrupt source.
    always_ff @(posedge clk) begin
        if (!rst_n)                  ctrl_q <= 2'b00;
        else if (reg_wr && ctrl_hit) ctrl_q <= bus_wdata[1:0];
    end

    nvm_busy_track u_busy (
        .clk(clk), .rst_n(rst_n),
        .op_start(op_start), .op_done(op_done), .op_suspend(op_suspend),
        .op_err(op_err), .err_clr(err_clr),
        .op_busy(op_busy), .eow_irq(eow_irq), .err_flag(err_flag)
    );

    nvm_pwr_seq #(.PWRUP_CYC(PWRUP_CYC), .RECOV_CYC(RECOV_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .lp_req(lp_req), .lp_halt(lp_halt), .lp_wake(lp_wake),
        .pd_on_wfi(ctrl_q[0]), .op_busy(op_busy),
        .arr_stby(arr_stby), .arr_pd(arr_pd),
        .in_recov(in_recov), .mem_stall(mem_stall)
    );

    nvm_sect_map #(.MAIN_SECT(MAIN_SECT)) u_map (
        .test_busy(test_busy), .eep_busy(eep_busy),
        .main_busy(main_busy), .sect_stat(sect_stat)
    );

    // Array-side gating: stall first, then shield while an operation runs.
    always_comb begin
        bus_wait  = bus_req && bus_sel_mem && mem_stall;
        mem_rd_ok = bus_req && bus_sel_mem && !bus_we && !mem_stall && !op_busy;
        mem_wr_ok = bus_req && bus_sel_mem &&  bus_we && !mem_stall && !op_busy;
        mem_re    = mem_rd_ok;
        mem_we    = mem_wr_ok;
        mem_addr  = bus_addr;
        mem_wdata = bus_wdata;
    end

    // Read data mux.
    always_comb begin
        if (bus_sel_mem)   bus_rdata = op_busy ? NOP_BYTE : mem_rdata;
        else if (ctrl_hit) bus_rdata = {6'b0, ctrl_q};
        else if (stat_hit) bus_rdata = {err_flag, sect_stat};
        else               bus_rdata = 8'h00;
    end

    // Flag and interrupt-source outputs.
    always_comb begin
        busy    = op_busy || in_recov;
        irq_sel = ctrl_q[1];
    end

    a_r2_busy_reads_nop: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_sel_mem && !bus_we && op_busy && !bus_wait) |-> bus_rdata == NOP_BYTE);
    a_r2_busy_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        op_busy |-> !mem_we);
    a_r6_lp_after_op: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arr_pd || arr_stby) |-> $past(!op_busy));
    a_r7_recov_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !op_busy && bus_req && bus_sel_mem) |-> bus_wait);
endmodule

// File: tb/nvm_pwr_gate_test.sv
module nvm_pwr_gate_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int MS = 6;
    localparam int PU = 12;
    localparam int RC = 5;

    logic clk = 1'b0;
    logic rst_n;
    logic bus_req, bus_we, bus_sel_mem;
    logic [AW-1:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata, mem_rdata, mem_wdata;
    logic [AW-1:0] mem_addr;
    logic bus_wait, mem_re, mem_we;
    logic op_start, op_done, op_suspend, op_err;
    logic test_busy;
    logic [1:0] eep_busy;
    logic [MS-1:0] main_busy;
    logic lp_req, lp_halt, lp_wake;
    logic busy, arr_stby, arr_pd, eow_irq, irq_sel;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvm_pwr_gate #(.ADDR_W(AW), .MAIN_SECT(MS), .PWRUP_CYC(PU), .RECOV_CYC(RC)) uut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_sel_mem(bus_sel_mem), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_wait(bus_wait), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_re(mem_re), .mem_we(mem_we),
        .op_start(op_start), .op_done(op_done), .op_suspend(op_suspend), .op_err(op_err),
        .test_busy(test_busy), .eep_busy(eep_busy), .main_busy(main_busy),
        .lp_req(lp_req), .lp_halt(lp_halt), .lp_wake(lp_wake),
        .busy(busy), .arr_stby(arr_stby), .arr_pd(arr_pd),
        .eow_irq(eow_irq), .irq_sel(irq_sel)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_rd(input int a, output logic [7:0] d);
        bus_req = 1; bus_we = 0; bus_sel_mem = 0; bus_addr = AW'(a);
        #1 d = bus_rdata;
        bus_req = 0;
    endtask

    task automatic reg_wr(input int a, input logic [7:0] d);
        bus_req = 1; bus_we = 1; bus_sel_mem = 0; bus_addr = AW'(a); bus_wdata = d;
        step();
        bus_req = 0; bus_we = 0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy === 1'b1 && n < 100) begin
            n++;
            step();
        end
    endtask

    task automatic pulse_start();
        op_start = 1; step(); op_start = 0;
    endtask

    logic [7:0] rd;
    int n;

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; bus_req = 0; bus_we = 0; bus_sel_mem = 0; bus_addr = '0;
        bus_wdata = 0; mem_rdata = 0; op_start = 0; op_done = 0; op_suspend = 0;
        op_err = 0; test_busy = 0; eep_busy = 0; main_busy = 0;
        lp_req = 0; lp_halt = 0; lp_wake = 0;
        repeat (3) @(negedge clk);

        // Reset state
        chk("R7 busy during reset", busy, 1);
        bus_req = 1; bus_sel_mem = 1; bus_we = 0;
        #1 chk("R7 wait during reset", bus_wait, 1);
        chk("R7 no read during reset", mem_re, 0);
        bus_req = 0;
        reg_rd(1, rd); chk("R8 status reset", rd, 0);
        reg_rd(0, rd); chk("R11 control reset", rd, 0);
        chk("R10 no pulse at reset", eow_irq, 0);
        chk("R4 no standby at reset", arr_stby, 0);
        chk("R5 no power-down at reset", arr_pd, 0);

        // R7 power-up window
        rst_n = 1;
        count_busy(n); chk("R7 power-up window", n, PU);

        // R3 pass-through sweep
        for (int v = 0; v < 256; v++) begin
            mem_rdata = 8'(v);
            bus_req = 1; bus_sel_mem = 1; bus_we = 0; bus_addr = AW'(v * 7);
            #1 chk("R3 read data", bus_rdata, v);
            chk("R3 read enable", mem_re, 1);
            chk("R3 no wait", bus_wait, 0);
        end
        bus_we = 1;
        #1 chk("R3 write enable", mem_we, 1);
        chk("R3 no read on write", mem_re, 0);
        bus_req = 0; bus_we = 0;

        // R1/R2 operation shielding
        pulse_start();
        chk("R1 busy after start", busy, 1);
        for (int k = 0; k < 4; k++) begin
            mem_rdata = 8'(k * 8'h5A);
            bus_req = 1; bus_sel_mem = 1; bus_we = 0;
            #1 chk("R2 read returns FF", bus_rdata, 8'hFF);
            chk("R2 read blocked", mem_re, 0);
            bus_we = 1;
            #1 chk("R2 write dropped", mem_we, 0);
            bus_req = 0; bus_we = 0;
            step();
        end
        op_done = 1; step(); op_done = 0;
        chk("R1 busy clears on done", busy, 0);
        chk("R10 end pulse", eow_irq, 1);
        step();
        chk("R10 pulse one cycle", eow_irq, 0);

        pulse_start();
        op_suspend = 1; step(); op_suspend = 0;
        chk("R1 busy clears on suspend", busy, 0);
        chk("R10 no pulse on suspend", eow_irq, 0);
        step();
        chk("R10 still no pulse", eow_irq, 0);

        // R11 control register
        reg_wr(0, 8'hFF);
        reg_rd(0, rd); chk("R11 readback FF", rd, 8'h03);
        chk("R11 irq_sel set", irq_sel, 1);
        reg_wr(0, 8'h02);
        reg_rd(0, rd); chk("R11 readback 02", rd, 8'h02);
        reg_wr(0, 8'h00);
        chk("R11 irq_sel clear", irq_sel, 0);

        // R8 failure flag
        op_err = 1; step(); op_err = 0;
        reg_rd(1, rd); chk("R8 set by err", rd, 8'h80);
        reg_wr(1, 8'h80);
        reg_rd(1, rd); chk("R8 write 1 keeps", rd, 8'h80);
        reg_wr(1, 8'h00);
        reg_rd(1, rd); chk("R8 write 0 clears", rd, 8'h00);
        op_err = 1; reg_wr(1, 8'h00); op_err = 0;
        reg_rd(1, rd); chk("R8 set beats clear", rd, 8'h80);
        reg_wr(1, 8'h00);

        // R9 sector sweep
        for (int c = 0; c < 512; c++) begin
            test_busy = c[8];
            eep_busy  = 2'(c >> 6);
            main_busy = 6'(c);
            reg_rd(1, rd);
            chk("R9 sector field", rd,
                (c[8] << 6) | (((c >> 6) & 3) << 4) | (((c & 8'h38) != 0) << 3) | (c & 7));
        end
        test_busy = 0; eep_busy = 0; main_busy = 0;
        reg_wr(1, 8'h7F);
        reg_rd(1, rd); chk("R9 write ignored", rd, 8'h00);

        // R4 wait with standby
        lp_req = 1; lp_halt = 0; step(); lp_req = 0;
        chk("R4 standby", arr_stby, 1);
        chk("R4 not power-down", arr_pd, 0);
        bus_req = 1; bus_sel_mem = 1; bus_we = 0;
        #1 chk("R7 wait in standby", bus_wait, 1);
        bus_req = 0;
        lp_wake = 1; step(); lp_wake = 0;
        chk("R4 standby left", arr_stby, 0);
        chk("R4 no recovery", busy, 0);
        bus_req = 1; bus_sel_mem = 1;
        #1 chk("R4 immediate read", bus_wait, 0);
        bus_req = 0;

        // R4 wait with power-down
        reg_wr(0, 8'h01);
        lp_req = 1; lp_halt = 0; step(); lp_req = 0;
        chk("R4 power-down", arr_pd, 1);
        chk("R4 not standby", arr_stby, 0);
        lp_wake = 1; step(); lp_wake = 0;
        chk("R4 power-down left", arr_pd, 0);
        count_busy(n); chk("R7 recovery window", n, RC);

        // R5 halt always powers down
        reg_wr(0, 8'h00);
        lp_req = 1; lp_halt = 1; step(); lp_req = 0; lp_halt = 0;
        chk("R5 halt power-down", arr_pd, 1);
        lp_wake = 1; step(); lp_wake = 0;
        count_busy(n); chk("R7 recovery after halt", n, RC);

        // R6 deferred entry
        pulse_start();
        lp_req = 1; lp_halt = 1; step(); lp_req = 0; lp_halt = 0;
        for (int k = 0; k < 3; k++) begin
            chk("R6 held while busy", arr_pd, 0);
            step();
        end
        op_done = 1; step(); op_done = 0;
        chk("R6 not yet at flag clear", arr_pd, 0);
        step();
        chk("R6 entered next edge", arr_pd, 1);
        lp_wake = 1; step(); lp_wake = 0;
        count_busy(n); chk("R7 recovery after deferred", n, RC);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule